// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates eight interrupt request inputs for a host processor and presents them through a two-address byte port that is register-compatible with the classic priority interrupt controller. Address 0 is the command port and address 1 is the mask/data port. After a start command and a short series of initialization words, the block latches requests, applies a per-input mask and fixed priority with input 0 highest, and raises an interrupt output when a request outranks everything already in service.

The host answers with a single-cycle acknowledge strobe. The block then returns an 8-bit vector built from a programmed 5-bit base and the 3-bit input number, and marks that input as in service. The in-service bit is cleared later by an end-of-interrupt command, or at once when auto end-of-interrupt is selected. If the request has gone by the time of the acknowledge, the block returns the lowest-priority vector without marking it. Each input is edge or level sensed according to a trigger-mode input, except for a parameterised set of reserved inputs that are always edge sensed.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF on address 1, the request and in-service registers are zero, `int_out` is low, and a read of address 0 returns the request register.
- R2: A command-port write with bit 4 set starts initialization: bit 0 set means a fourth word follows and bit 1 clear means a third word follows. The next data-port writes are taken in order as the vector base word (upper 5 bits kept), the cascade word (only if expected) and the mode word (only if expected). The mask register is untouched during this sequence, and data writes load it again once the sequence is done.
- R3: The cascade word is held and shown on `casc_word`. When single mode is chosen (bit 1 set in the start command) no cascade word is consumed and `casc_word` keeps its value.
- R4: Outside initialization a data-port write loads the mask register and a data-port read returns it. A mask bit of 1 keeps that input from raising `int_out`.
- R5: A command write of 0x0A makes later command-port reads return the request register, and 0x0B makes them return the in-service register. The choice persists until it is changed or initialization starts, which selects the request register.
- R6: Priority is fixed with input 0 highest. `int_out` is high only when an unmasked pending request has a smaller index than every set in-service bit.
- R7: An `int_ack` pulse while `int_out` is high gives `vec_out` = {base[4:0], winning index} with `vec_vld` high in the following cycle, and sets that input's in-service bit.
- R8: A command byte 0x60+n clears in-service bit n and no other bit.
- R9: A command byte 0x20 clears the highest-priority (lowest-index) set in-service bit.
- R10: With bit 1 of the mode word set (auto end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R11: An `int_ack` while `int_out` is low returns {base, 3'b111} and leaves the in-service register unchanged, including when input 7 is masked.
- R12: An edge-sensed input latches its request on a rising edge and keeps it until acknowledged, and a held-high input does not re-request after the acknowledge. A level-sensed input's request follows the input.
- R13: Inputs marked in `RESERVED_MASK` (default inputs 0 to 2) are edge sensed whatever `trig_mode` says. For the others, `trig_mode` bit 1 means level and bit 0 means edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | 1 | 0 = command port, 1 = mask/data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for `host_addr` (combinational) |
| irq_in | input | 8 | Interrupt request inputs, index 0 highest priority |
| trig_mode | input | 8 | Per-input sense: 1 level, 0 edge |
| int_out | output | 1 | Interrupt request to the host |
| int_ack | input | 1 | Single-cycle acknowledge strobe |
| vec_out | output | 8 | Vector captured at the acknowledge |
| vec_vld | output | 1 | `vec_out` valid, the cycle after `int_ack` |
| casc_word | output | 8 | Stored cascade configuration word |

## Verification
A host write takes effect at the next clock edge, so register reads (which are combinational) and `int_out` reflect it one cycle after the strobe. A rising request input is registered once, so `int_out` responds one cycle after the input changes. The acknowledge result (`vec_out`, `vec_vld`, in-service update and edge-request clear) all land at the edge that samples `int_ack`. The bench drives every input on a falling edge and samples on the next falling edge, which is exactly one rising edge later, so each check falls in the first cycle in which its result is due.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIC_N  = 8;
    localparam int PIC_IW = 3;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } init_st_t;

    typedef struct packed {
        logic [4:0]       base;
        logic             aeoi;
        logic [PIC_N-1:0] casc;
        logic             single;
        logic             want_mode;
    } pic_cfg_t;

    typedef struct packed {
        logic              spec;
        logic              nonspec;
        logic [PIC_IW-1:0] idx;
    } eoi_cmd_t;

    localparam logic [2:0] EOI_SPEC_CODE    = 3'b011;
    localparam logic [2:0] EOI_NONSPEC_CODE = 3'b001;

    // Index of the lowest set bit, or PIC_N when none is set.
    function automatic logic [PIC_IW:0] first_set(input logic [PIC_N-1:0] v);
        logic [PIC_IW:0] r;
        r = (PIC_IW+1)'(PIC_N);
        for (int i = PIC_N - 1; i >= 0; i--) begin
            if (v[i]) r = (PIC_IW+1)'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_host_regs.sv
module pic_host_regs
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [PIC_N-1:0] wdata,
    output pic_cfg_t         cfg,
    output logic [PIC_N-1:0] imr,
    output logic             sel_isr,
    output logic             ready,
    output logic             init_pulse,
    output eoi_cmd_t         eoi
);

    init_st_t st_q;

    logic cmd_wr, data_wr;
    assign cmd_wr  = wr_en && !addr;
    assign data_wr = wr_en && addr;

    assign init_pulse = cmd_wr && wdata[4];
    assign ready      = (st_q == ST_READY);

    always_comb begin
        eoi.spec    = cmd_wr && !wdata[4] && !wdata[3] && (wdata[7:5] == EOI_SPEC_CODE);
        eoi.nonspec = cmd_wr && !wdata[4] && !wdata[3] && (wdata[7:5] == EOI_NONSPEC_CODE);
        eoi.idx     = wdata[PIC_IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_READY;
            cfg     <= '0;
            imr     <= '1;
            sel_isr <= 1'b0;
        end else if (init_pulse) begin
            st_q          <= ST_BASE;
            cfg.want_mode <= wdata[0];
            cfg.single    <= wdata[1];
            cfg.aeoi      <= 1'b0;
            sel_isr       <= 1'b0;
        end else if (cmd_wr) begin
            if (wdata[3] && wdata[1]) begin
                sel_isr <= wdata[0];
            end
        end else if (data_wr) begin
            unique case (st_q)
                ST_BASE: begin
                    cfg.base <= wdata[7:3];
                    if (!cfg.single)        st_q <= ST_CASC;
                    else if (cfg.want_mode) st_q <= ST_MODE;
                    else                    st_q <= ST_READY;
                end
                ST_CASC: begin
                    cfg.casc <= wdata;
                    st_q     <= cfg.want_mode ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    cfg.aeoi <= wdata[1];
                    st_q     <= ST_READY;
                end
                default: begin
                    imr <= wdata;
                end
            endcase
        end
    end

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_pkg::*;
#(
    parameter logic [PIC_N-1:0] RESERVED_MASK = 8'h07
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIC_N-1:0] irq_in,
    input  logic [PIC_N-1:0] trig_mode,
    input  logic [PIC_N-1:0] clr,
    output logic [PIC_N-1:0] irr
);

    logic [PIC_N-1:0] lvl_sel;
    assign lvl_sel = trig_mode & ~RESERVED_MASK;

    for (genvar g = 0; g < PIC_N; g++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                irr[g] <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (lvl_sel[g])                irr[g] <= irq_in[g];
                else if (irq_in[g] && !prev_q) irr[g] <= 1'b1;
                else if (clr[g])               irr[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIC_N-1:0] irr,
    input  logic [PIC_N-1:0] imr,
    input  logic             ready,
    input  logic [4:0]       base,
    input  logic             aeoi,
    input  logic             ack,
    input  logic             init_pulse,
    input  eoi_cmd_t         eoi,
    output logic [PIC_N-1:0] isr,
    output logic [PIC_N-1:0] clr,
    output logic             int_req,
    output logic [7:0]       vec_out,
    output logic             vec_vld
);

    logic [PIC_IW:0]  win, top;
    logic             grant;
    logic [PIC_N-1:0] isr_d;

    assign win     = first_set(irr & ~imr);
    assign top     = first_set(isr);
    assign int_req = ready && (win < top);
    assign grant   = ack && int_req;

    always_comb begin
        clr = '0;
        if (grant) clr[win[PIC_IW-1:0]] = 1'b1;
    end

    always_comb begin
        isr_d = isr;
        if (init_pulse) begin
            isr_d = '0;
        end else begin
            if (eoi.spec)                isr_d[eoi.idx] = 1'b0;
            if (eoi.nonspec && !top[PIC_IW]) isr_d[top[PIC_IW-1:0]] = 1'b0;
            if (grant && !aeoi)          isr_d[win[PIC_IW-1:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            vec_out <= '0;
            vec_vld <= 1'b0;
        end else begin
            isr     <= isr_d;
            vec_vld <= ack;
            if (ack) vec_out <= {base, grant ? win[PIC_IW-1:0] : 3'd7};
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter logic [PIC_N-1:0] RESERVED_MASK = 8'h07
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_addr,
    input  logic [PIC_N-1:0] host_wdata,
    output logic [PIC_N-1:0] host_rdata,
    input  logic [PIC_N-1:0] irq_in,
    input  logic [PIC_N-1:0] trig_mode,
    output logic             int_out,
    input  logic             int_ack,
    output logic [7:0]       vec_out,
    output logic             vec_vld,
    output logic [PIC_N-1:0] casc_word
);

    pic_cfg_t         cfg_q;
    logic [PIC_N-1:0] imr_q, irr_q, isr_q, clr_w;
    logic             sel_isr, ready_w, init_pulse_w;
    eoi_cmd_t         eoi_w;
    logic             aeoi_w, eoi_spec_w, eoi_nspec_w;
    logic [PIC_IW-1:0] eoi_idx_w;

    pic_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .cfg        (cfg_q),
        .imr        (imr_q),
        .sel_isr    (sel_isr),
        .ready      (ready_w),
        .init_pulse (init_pulse_w),
        .eoi        (eoi_w)
    );

    pic_req_latch #(.RESERVED_MASK(RESERVED_MASK)) u_req (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .trig_mode (trig_mode),
        .clr       (clr_w),
        .irr       (irr_q)
    );

    pic_resolver u_res (
        .clk        (clk),
        .rst        (rst),
        .irr        (irr_q),
        .imr        (imr_q),
        .ready      (ready_w),
        .base       (cfg_q.base),
        .aeoi       (cfg_q.aeoi),
        .ack        (int_ack),
        .init_pulse (init_pulse_w),
        .eoi        (eoi_w),
        .isr        (isr_q),
        .clr        (clr_w),
        .int_req    (int_out),
        .vec_out    (vec_out),
        .vec_vld    (vec_vld)
    );

    assign host_rdata  = host_addr ? imr_q : (sel_isr ? isr_q : irr_q);
    assign casc_word   = cfg_q.casc;
    assign aeoi_w      = cfg_q.aeoi;
    assign eoi_spec_w  = eoi_w.spec;
    assign eoi_nspec_w = eoi_w.nonspec;
    assign eoi_idx_w   = eoi_w.idx;

endmodule

// File: rtl/pic_checker.sv
module pic_checker (
    input logic       clk,
    input logic       rst,
    input logic       int_ack,
    input logic       int_out,
    input logic       vec_vld,
    input logic [7:0] vec_out,
    input logic [7:0] isr,
    input logic [7:0] imr,
    input logic [7:0] irr,
    input logic       aeoi,
    input logic       eoi_spec,
    input logic       eoi_nspec,
    input logic [2:0] eoi_idx,
    input logic       init_pulse
);

    logic eoi_any;
    assign eoi_any = eoi_spec || eoi_nspec || init_pulse;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (imr == 8'hFF && isr == 8'h00 && irr == 8'h00));

    p_int_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != 8'h00));

    p_ack_vld_r7: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> vec_vld);

    p_vld_only_ack_r7: assert property (@(posedge clk) disable iff (rst)
        !int_ack |=> !vec_vld);

    p_spec_eoi_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi_spec && !int_ack && !init_pulse) |=> !isr[$past(eoi_idx)]);

    p_aeoi_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (int_ack && aeoi && !eoi_any) |=> (isr == $past(isr)));

    p_spur_vec_r11: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_out) |=> (vec_out[2:0] == 3'd7));

    p_spur_isr_r11: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_out && !eoi_any) |=> (isr == $past(isr)));

endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .int_ack    (int_ack),
    .int_out    (int_out),
    .vec_vld    (vec_vld),
    .vec_out    (vec_out),
    .isr        (isr_q),
    .imr        (imr_q),
    .irr        (irr_q),
    .aeoi       (aeoi_w),
    .eoi_spec   (eoi_spec_w),
    .eoi_nspec  (eoi_nspec_w),
    .eoi_idx    (eoi_idx_w),
    .init_pulse (init_pulse_w)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] irq_in = 8'h00;
    logic [7:0] trig_mode = 8'h00;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_vld;
    logic [7:0] casc_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
        .trig_mode(trig_mode), .int_out(int_out), .int_ack(int_ack),
        .vec_out(vec_out), .vec_vld(vec_vld), .casc_word(casc_word)
    );

    // {write, addr, data, expected read}
    localparam int NOPS = 12;
    localparam logic [17:0] OPS [NOPS] = '{
        {1'b0, 1'b1, 8'h00, 8'hFF},
        {1'b0, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'h11, 8'h00},
        {1'b1, 1'b1, 8'h20, 8'h00},
        {1'b1, 1'b1, 8'h04, 8'h00},
        {1'b1, 1'b1, 8'h01, 8'h00},
        {1'b1, 1'b1, 8'hA5, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'hA5},
        {1'b1, 1'b0, 8'h0B, 8'h00},
        {1'b0, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic ack();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 int_out after reset", {7'd0, int_out}, 8'h00);
        check("R1 vec_vld after reset", {7'd0, vec_vld}, 8'h00);

        // R1 R2 R4 R5: register table
        for (int i = 0; i < NOPS; i++) begin
            if (OPS[i][17]) wr(OPS[i][16], OPS[i][15:8]);
            else            rd(OPS[i][16], OPS[i][7:0], "R1/R4/R5 table read");
        end
        check("R3 cascade word stored", casc_word, 8'h04);

        // R12 R7: edge request, acknowledge, no re-request while held
        set_irq(8'h20);
        check("R12 edge latch raises int", {7'd0, int_out}, 8'h01);
        ack();
        check("R7 vld", {7'd0, vec_vld}, 8'h01);
        check("R7 vector IR5", vec_out, 8'h25);
        rd(1'b0, 8'h20, "R7 ISR bit5 set");
        check("R12 edge held high no re-request", {7'd0, int_out}, 8'h00);

        // R6: lower priority blocked, higher passes
        set_irq(8'h60);
        check("R6 IR6 blocked by ISR5", {7'd0, int_out}, 8'h00);
        set_irq(8'h64);
        check("R6 IR2 above ISR5", {7'd0, int_out}, 8'h01);
        ack();
        check("R6 vector IR2", vec_out, 8'h22);
        rd(1'b0, 8'h24, "R7 ISR 2 and 5");

        // R8: specific EOI
        wr(1'b0, 8'h62);
        rd(1'b0, 8'h20, "R8 specific EOI clears only bit2");
        check("R6 IR6 still blocked", {7'd0, int_out}, 8'h00);

        // R9: non-specific EOI
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h00, "R9 nonspecific EOI clears bit5");
        check("R9 IR6 now raises int", {7'd0, int_out}, 8'h01);
        ack();
        check("R7 vector IR6", vec_out, 8'h26);
        wr(1'b0, 8'h66);
        irq_in = 8'h00;

        // R11: spurious with all masked
        wr(1'b1, 8'hFF);
        ack();
        check("R11 spurious vector", vec_out, 8'h27);
        rd(1'b0, 8'h00, "R11 ISR unchanged");
        set_irq(8'h08);
        check("R4 masked IR3 no int", {7'd0, int_out}, 8'h00);
        ack();
        check("R11 spurious with masked request", vec_out, 8'h27);
        rd(1'b0, 8'h00, "R11 ISR still clear");
        wr(1'b1, 8'hF7);
        check("R4 unmask IR3 raises int", {7'd0, int_out}, 8'h01);
        ack();
        check("R4 vector IR3", vec_out, 8'h23);
        wr(1'b0, 8'h63);
        irq_in = 8'h00;

        // R12 R13: level sensing and reserved inputs
        wr(1'b1, 8'h00);
        @(negedge clk);
        trig_mode = 8'hFF;
        set_irq(8'h08);
        check("R12 level IR3 raises int", {7'd0, int_out}, 8'h01);
        ack();
        check("R12 level vector", vec_out, 8'h23);
        wr(1'b0, 8'h63);
        check("R12 level still high re-requests", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        check("R12 level follows input low", {7'd0, int_out}, 8'h00);
        set_irq(8'h02);
        check("R13 reserved IR1 latches", {7'd0, int_out}, 8'h01);
        ack();
        check("R13 vector IR1", vec_out, 8'h21);
        wr(1'b0, 8'h61);
        check("R13 reserved IR1 edge only", {7'd0, int_out}, 8'h00);
        irq_in = 8'h00;
        trig_mode = 8'h00;

        // R2 R3 R10 R5: single mode re-init with auto-EOI
        wr(1'b1, 8'h5A);
        wr(1'b0, 8'h13);
        rd(1'b0, 8'h00, "R5 init selects IRR");
        wr(1'b1, 8'h48);
        wr(1'b1, 8'h02);
        rd(1'b1, 8'h5A, "R2 init words skip IMR");
        check("R3 single mode keeps cascade", casc_word, 8'h04);
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R2 IMR after sequence");
        wr(1'b0, 8'h0B);
        set_irq(8'h10);
        check("R10 int on IR4", {7'd0, int_out}, 8'h01);
        ack();
        check("R2 new base vector", vec_out, 8'h4C);
        rd(1'b0, 8'h00, "R10 auto EOI leaves ISR clear");
        irq_in = 8'h00;

        // R1: mid-run reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(1'b1, 8'hFF, "R1 IMR after reset");
        rd(1'b0, 8'h00, "R1 IRR after reset");
        check("R1 int low after reset", {7'd0, int_out}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule